// File: doc/BRIEF.md
# Exception Control Register Unit

This unit holds the three system-control registers that a 32-bit RISC core needs to take and return from exceptions. The registers are a processor status word, an exception cause word and a saved exception program counter. Software reads them with a move-from operation and writes them with a move-to operation. Both operations pick a register by a 5-bit number. The read path is combinational, and a write lands on the next clock edge.

When the pipeline retires a faulting instruction, it pulses a commit strobe. With the strobe it supplies a 5-bit cause code, the faulting PC and a flag that says whether that instruction sat in a branch delay slot. The unit records these values and raises the exception level. It reports whether the core is in kernel mode. It also gives the fixed handler entry address and the return address that the exception-return operation loads into the PC.

The unit samples eight interrupt request lines into the cause word every cycle. It raises one qualified interrupt request when an unmasked line is pending and interrupts are allowed.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, registers 12, 13 and 14 read zero, `kernel_mode` is 1 and `irq_pending` is 0.
- R2: Register 12 (status) keeps only these bits from a write: mask [15:8], user-mode bit 4, error-level bit 2, exception-level bit 1 and interrupt-enable bit 0. All other bits read zero, so writing all ones reads back 0x0000FF17.
- R3: `kernel_mode` is 1 when user-mode (bit 4) is 0, or when exception-level (bit 1) or error-level (bit 2) is 1. Otherwise it is 0.
- R4: A commit pulse sets exception-level to 1 on the next edge, even when the same cycle carries a software write of 0 to register 12. On that edge the code is stored in register 13 bits [6:2] and the faulting PC is stored in register 14.
- R5: When a commit has the delay-slot flag set, register 14 holds the faulting PC minus 4 and register 13 bit 31 is 1. Without the flag, bit 31 is 0.
- R6: An exception-return pulse clears exception-level on the next edge. A commit in the same cycle wins, and exception-level stays 1. `return_addr` always equals register 14.
- R7: `handler_addr` is 0x80000180 at all times.
- R8: Register 13 bits [15:8] equal `irq_lines` as it was one edge earlier. A software write to register 13 changes nothing in that register.
- R9: `irq_pending` is 1 exactly when some line i has pending bit i = 1 and mask bit i = 0, interrupt-enable is 1, and both exception-level and error-level are 0. A mask bit of 1 ignores its line.
- R10: Register 14 is readable and writable in full through register number 14. Every register number other than 12, 13 and 14 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel | input | 5 | Register number for move-from |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Move-to strobe |
| wr_sel | input | 5 | Register number for move-to |
| wr_data | input | 32 | Move-to data |
| exc_commit | input | 1 | Faulting instruction retires this cycle |
| exc_code | input | 5 | Cause code of the commit |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_slot | input | 1 | Faulting instruction was in a delay slot |
| eret | input | 1 | Exception-return operation |
| irq_lines | input | 8 | Raw interrupt request lines |
| handler_addr | output | 32 | Handler entry address |
| return_addr | output | 32 | Address loaded into the PC on return |
| kernel_mode | output | 1 | Core is in kernel mode |
| irq_pending | output | 1 | Qualified interrupt request |

## Verification
Reads through `rd_sel` need no clock edge, and `kernel_mode` follows the status register with no added delay. A move-to write, a commit or an exception return shows up after exactly one rising edge. A change on `irq_lines` reaches the pending bits and `irq_pending` after one rising edge. The bench drives every stimulus just after a falling edge. It checks at the next falling edge, which is half a period after the single register stage has updated. Combinational reads are checked a fraction of a nanosecond after `rd_sel` is set. The bench sweeps every request pattern against sixteen mask values, all eight gating combinations, and every cause code both with and without the delay-slot flag.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int XLEN      = 32;
  localparam int IRQ_N     = 8;
  localparam int SEL_W     = 5;
  localparam int CODE_W    = 5;

  localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

  // status bit positions
  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_UM  = 4;
  localparam int ST_IM  = 8;
  // cause bit positions
  localparam int CA_CODE = 2;
  localparam int CA_PI   = 8;
  localparam int CA_BD   = 31;

  typedef enum logic [CODE_W-1:0] {
    CODE_IRQ         = 5'd0,
    CODE_LOAD_ALIGN  = 5'd4,
    CODE_STORE_ALIGN = 5'd5,
    CODE_FETCH_BUS   = 5'd6,
    CODE_DATA_BUS    = 5'd7,
    CODE_SYSCALL     = 5'd8,
    CODE_BREAK       = 5'd9,
    CODE_BAD_OP      = 5'd10,
    CODE_COP_OFF     = 5'd11,
    CODE_OVERFLOW    = 5'd12,
    CODE_TRAP        = 5'd13,
    CODE_FPU         = 5'd15
  } exc_code_e;

  typedef struct packed {
    logic [IRQ_N-1:0] im;
    logic             um;
    logic             erl;
    logic             exl;
    logic             ie;
  } status_t;
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            commit,
  input  logic            eret,
  output status_t         status
);
  status_t st_d, st_q;
  logic    st_en;

  assign st_en = wr_en | commit | eret;

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      st_d.im  = wr_data[ST_IM +: IRQ_N];
      st_d.um  = wr_data[ST_UM];
      st_d.erl = wr_data[ST_ERL];
      st_d.exl = wr_data[ST_EXL];
      st_d.ie  = wr_data[ST_IE];
    end
    if (eret)   st_d.exl = 1'b0;
    if (commit) st_d.exl = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign status = st_q;

  assert_exl_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> status.exl);
  assert_eret_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !commit) |=> !status.exl);
  assert_status_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !commit && !eret) |=> $stable(status));
endmodule

// File: rtl/exc_cause_epc.sv
module exc_cause_epc
  import exc_ctrl_pkg::*;
#(
  parameter int SLOT_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              epc_wr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              commit,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   pc,
  input  logic              in_slot,
  input  logic [IRQ_N-1:0]  irq_lines,
  output logic              bd,
  output logic [CODE_W-1:0] code_q,
  output logic [IRQ_N-1:0]  pi,
  output logic [XLEN-1:0]   epc
);
  logic [XLEN-1:0]   epc_d, epc_q;
  logic              epc_en;
  logic              bd_q;
  logic [CODE_W-1:0] cq;
  logic [IRQ_N-1:0]  pi_q;

  assign epc_en = commit | epc_wr;

  always_comb begin
    if (commit) epc_d = in_slot ? (pc - XLEN'(SLOT_OFFSET)) : pc;
    else        epc_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      epc_q <= '0;
    else if (epc_en) epc_q <= epc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bd_q <= 1'b0;
      cq   <= '0;
    end else if (commit) begin
      bd_q <= in_slot;
      cq   <= code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pi_q <= '0;
    else        pi_q <= irq_lines;
  end

  assign bd     = bd_q;
  assign code_q = cq;
  assign pi     = pi_q;
  assign epc    = epc_q;

  assert_pi_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pi == $past(irq_lines));
  assert_bd_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> bd == $past(in_slot));
  assert_slot_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && in_slot) |=> epc == $past(pc) - XLEN'(SLOT_OFFSET));
  assert_code_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> code_q == $past(code));
endmodule

// File: rtl/exc_irq_qual.sv
module exc_irq_qual
  import exc_ctrl_pkg::*;
(
  input  logic [IRQ_N-1:0] pi,
  input  status_t          status,
  output logic             irq_pending
);
  logic [IRQ_N-1:0] hit;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_line
    assign hit[i] = pi[i] & ~status.im[i];
  end

  assign irq_pending = (|hit) & status.ie & ~status.exl & ~status.erl;
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_ctrl_pkg::*;
#(
  parameter logic [31:0] HANDLER_ADDR = 32'h8000_0180,
  parameter int          SLOT_OFFSET  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        wr_en,
  input  logic [4:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        exc_commit,
  input  logic [4:0]  exc_code,
  input  logic [31:0] exc_pc,
  input  logic        exc_in_slot,
  input  logic        eret,
  input  logic [7:0]  irq_lines,
  output logic [31:0] handler_addr,
  output logic [31:0] return_addr,
  output logic        kernel_mode,
  output logic        irq_pending
);
  logic              srst_n;
  status_t           status;
  logic              bd;
  logic [CODE_W-1:0] code_q;
  logic [IRQ_N-1:0]  pi;
  logic [XLEN-1:0]   epc;
  logic              st_wr, epc_wr;

  assign st_wr  = wr_en && (wr_sel == SEL_STATUS);
  assign epc_wr = wr_en && (wr_sel == SEL_EPC);

  exc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  exc_status_reg u_status (
    .clk(clk), .rst_n(srst_n), .wr_en(st_wr), .wr_data(wr_data),
    .commit(exc_commit), .eret(eret), .status(status)
  );

  exc_cause_epc #(.SLOT_OFFSET(SLOT_OFFSET)) u_cause (
    .clk(clk), .rst_n(srst_n), .epc_wr(epc_wr), .wr_data(wr_data),
    .commit(exc_commit), .code(exc_code), .pc(exc_pc), .in_slot(exc_in_slot),
    .irq_lines(irq_lines), .bd(bd), .code_q(code_q), .pi(pi), .epc(epc)
  );

  exc_irq_qual u_irq (
    .pi(pi), .status(status), .irq_pending(irq_pending)
  );

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_STATUS: begin
        rd_data[ST_IM +: IRQ_N] = status.im;
        rd_data[ST_UM]          = status.um;
        rd_data[ST_ERL]         = status.erl;
        rd_data[ST_EXL]         = status.exl;
        rd_data[ST_IE]          = status.ie;
      end
      SEL_CAUSE: begin
        rd_data[CA_BD]              = bd;
        rd_data[CA_PI +: IRQ_N]     = pi;
        rd_data[CA_CODE +: CODE_W]  = code_q;
      end
      SEL_EPC: rd_data = epc;
      default: rd_data = '0;
    endcase
  end

  assign handler_addr = HANDLER_ADDR;
  assign return_addr  = epc;
  assign kernel_mode  = ~status.um | status.exl | status.erl;

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!srst_n)
    irq_pending |-> (status.ie && !status.exl && !status.erl && (pi != '0)));
  assert_commit_kernel_R3: assert property (@(posedge clk) disable iff (!srst_n)
    exc_commit |=> kernel_mode);
endmodule

// File: tb/tb_exc_ctrl_unit.sv
`timescale 1ns/1ps
module tb_exc_ctrl_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_sel;
  logic [31:0] rd_data;
  logic        wr_en;
  logic [4:0]  wr_sel;
  logic [31:0] wr_data;
  logic        exc_commit;
  logic [4:0]  exc_code;
  logic [31:0] exc_pc;
  logic        exc_in_slot;
  logic        eret;
  logic [7:0]  irq_lines;
  logic [31:0] handler_addr, return_addr;
  logic        kernel_mode, irq_pending;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  exc_ctrl_unit dut (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_data(rd_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .exc_commit(exc_commit), .exc_code(exc_code), .exc_pc(exc_pc),
    .exc_in_slot(exc_in_slot), .eret(eret), .irq_lines(irq_lines),
    .handler_addr(handler_addr), .return_addr(return_addr),
    .kernel_mode(kernel_mode), .irq_pending(irq_pending)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] s, output logic [31:0] v);
    rd_sel = s;
    #0.5;
    v = rd_data;
  endtask

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int codes [12] = '{0, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 15};
    rst_n = 1'b0; rd_sel = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    exc_commit = 1'b0; exc_code = '0; exc_pc = '0; exc_in_slot = 1'b0;
    eret = 1'b0; irq_lines = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    rd(5'd12, v); chk("R1 status", v, 32'h0);
    rd(5'd13, v); chk("R1 cause", v, 32'h0);
    rd(5'd14, v); chk("R1 epc", v, 32'h0);
    chk("R1 kernel", {31'b0, kernel_mode}, 32'h1);
    chk("R1 irq", {31'b0, irq_pending}, 32'h0);
    // R7
    chk("R7 handler", handler_addr, 32'h8000_0180);

    // R2 writable bits
    wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd12, v); chk("R2 mask", v, 32'h0000_FF17);
    wr(5'd12, 32'h0000_A500);
    rd(5'd12, v); chk("R2 im", v, 32'h0000_A500);

    // R3 kernel mode over all level/mode combinations
    for (int k = 0; k < 8; k++) begin
      logic um, erl, exl;
      um = k[2]; erl = k[1]; exl = k[0];
      wr(5'd12, {27'b0, um, 1'b0, erl, exl, 1'b0});
      chk("R3 kernel", {31'b0, kernel_mode}, {31'b0, (!um || erl || exl)});
    end

    // R10 EPC access and unused numbers
    wr(5'd14, 32'hDEAD_BEE0);
    rd(5'd14, v); chk("R10 epc rw", v, 32'hDEAD_BEE0);
    chk("R6 return", return_addr, 32'hDEAD_BEE0);
    for (int s = 0; s < 32; s++) begin
      if (s < 12 || s > 14) begin
        rd(5'(s), v); chk("R10 zero", v, 32'h0);
      end
    end

    // R8 software write to cause ignored
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, v); chk("R8 cause ro", v, 32'h0);

    // R9 / R8 sweep: 16 masks x 256 patterns
    for (int m = 0; m < 256; m += 17) begin
      wr(5'd12, {16'b0, 8'(m), 8'h01});
      for (int p = 0; p < 256; p++) begin
        irq_lines = 8'(p);
        tick();
        chk("R9 pending", {31'b0, irq_pending}, {31'b0, |(8'(p) & ~8'(m))});
        rd(5'd13, v); chk("R8 pi", {24'b0, v[15:8]}, 32'(p));
      end
    end
    // R9 gating
    for (int g = 0; g < 8; g++) begin
      logic ie, exl, erl;
      ie = g[0]; exl = g[1]; erl = g[2];
      wr(5'd12, {29'b0, erl, exl, ie});
      irq_lines = 8'h80;
      tick();
      chk("R9 gate", {31'b0, irq_pending}, {31'b0, ie && !exl && !erl});
    end
    irq_lines = 8'h00;
    tick();

    // R4 / R5 commit sweep
    for (int c = 0; c < 12; c++) begin
      for (int sl = 0; sl < 2; sl++) begin
        logic [31:0] pc;
        wr(5'd12, 32'h0000_0010);
        pc = 32'h0040_1000 + 32'(c * 16);
        exc_commit = 1'b1; exc_code = 5'(codes[c]); exc_pc = pc;
        exc_in_slot = sl[0];
        tick();
        exc_commit = 1'b0; exc_in_slot = 1'b0;
        rd(5'd13, v);
        chk("R5 cause", v, {sl[0], 24'b0, 5'(codes[c]), 2'b0});
        rd(5'd14, v);
        chk("R5 epc", v, sl[0] ? pc - 32'd4 : pc);
        chk("R6 return", return_addr, sl[0] ? pc - 32'd4 : pc);
        rd(5'd12, v); chk("R4 exl", v, 32'h0000_0012);
        chk("R3 kernel", {31'b0, kernel_mode}, 32'h1);
      end
    end

    // R6 return clears exl
    eret = 1'b1; tick(); eret = 1'b0;
    rd(5'd12, v); chk("R6 eret", v, 32'h0000_0010);
    chk("R3 user", {31'b0, kernel_mode}, 32'h0);
    // R6 commit wins over return
    exc_commit = 1'b1; eret = 1'b1; exc_pc = 32'h1000; exc_code = 5'd8;
    tick();
    exc_commit = 1'b0; eret = 1'b0;
    rd(5'd12, v); chk("R6 priority", v, 32'h0000_0012);
    // R4 commit wins over software write of 0
    eret = 1'b1; tick(); eret = 1'b0;
    exc_commit = 1'b1; wr_en = 1'b1; wr_sel = 5'd12; wr_data = 32'h0;
    tick();
    exc_commit = 1'b0; wr_en = 1'b0;
    rd(5'd12, v); chk("R4 over write", v, 32'h0000_0002);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule